// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the word a host sees when it reads a flash bank whose internal program or erase operation is running. When a read hits that bank while the engine reports busy, or while a failed operation is still flagged, the block returns a status word instead of array data. The word holds three flags:

- a data-polling bit, which reads as the inverse of the value being written;
- a toggle bit, which changes on every status read;
- a timeout bit, which copies the engine's timer indication.

Reads of any other bank, and all reads once the operation has ended, return the array data unchanged.

The operation engine pulses a start strobe when an operation begins. With that strobe it gives the bank, whether the operation is an erase, and the target value of data bit 7. The block latches these for the whole operation, and the start strobe also clears the toggle. The host side gives one read strobe per access, together with the bank address of the read and the array data for that access. The selected word appears on the output register one clock after the strobe. It then holds until the next strobe.

Top module: `flg_status_gen`

## Requirements
- R1: After reset is asserted, `rd_data_o` is all zeros.
- R2: `rd_data_o` is loaded on the clock edge at which `rd_stb_i` is high, so it is valid in the following cycle. It holds its value in every cycle without a strobe.
- R3: A read while neither `op_busy_i` nor `op_fail_i` is high returns `array_data_i` unchanged.
- R4: While status mode is active, a read whose `rd_bank_i` differs from the bank latched at the last `op_start_i` returns `array_data_i` and leaves the toggle bit unchanged.
- R5: The toggle bit is bit 6 of the status word. It is cleared by `op_start_i`, so the first status read of an operation returns 0. Each later status read returns the inverse of the previous one.
- R6: Once busy and fail are both low, a read of the operation's bank returns array data. A new operation starts again with toggle 0.
- R7: During a program (`op_erase_i` = 0 at start), status bit 7 reads the inverse of `tgt_bit_i` as latched at start.
- R8: During an erase (`op_erase_i` = 1 at start), status bit 7 reads 0, whatever `tgt_bit_i` is.
- R9: Status bit 5 equals `op_tmo_i` at the read. The toggle bit keeps alternating while the timeout is set.
- R10: While `op_fail_i` is high, status reads continue: bit 7 stays inverted and bit 6 keeps toggling, even with `op_busy_i` low.
- R11: All status word bits other than 7, 6 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | Operation start pulse; latches context and clears the toggle |
| op_erase_i | input | 1 | Operation is an erase (sampled at start) |
| tgt_bit_i | input | 1 | Target value of data bit 7 (sampled at start) |
| op_bank_i | input | BANK_W | Bank of the operation (sampled at start) |
| op_busy_i | input | 1 | Engine busy |
| op_fail_i | input | 1 | Engine reports failed operation |
| op_tmo_i | input | 1 | Engine internal timer expired |
| rd_stb_i | input | 1 | One-cycle strobe per read access |
| rd_bank_i | input | BANK_W | Bank addressed by the read |
| array_data_i | input | DATA_W | Array data for the read |
| rd_data_o | output | DATA_W | Read data or status word |

## Verification
The bench builds the block with DATA_W = 16 and BANK_W = 3, so there are eight banks. This is enough room for status reads on one bank to be interleaved with reads on other banks. It also makes the all-zero upper byte of the status word observable.

With a 16-bit word, a reserved bit set by mistake, or a poll bit placed in the wrong position, shows up as a value mismatch. Three stimulus pairs are chosen so that a missing latch would flip bit 7:

- a program with target bit 1;
- a program with target bit 0;
- an erase with target bit 0.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int unsigned POLL_POS = 7;
  localparam int unsigned TOG_POS  = 6;
  localparam int unsigned TMO_POS  = 5;
  localparam int unsigned STAT_W   = 8;

  localparam logic [STAT_W-1:0] STAT_MASK =
    STAT_W'((1 << POLL_POS) | (1 << TOG_POS) | (1 << TMO_POS));

  function automatic logic [STAT_W-1:0] pack_status(input logic tgt,
                                                     input logic tog,
                                                     input logic tmo);
    logic [STAT_W-1:0] w;
    w           = '0;
    w[POLL_POS] = ~tgt;
    w[TOG_POS]  = tog;
    w[TMO_POS]  = tmo;
    return w;
  endfunction
endpackage

// File: rtl/flg_op_ctx.sv
module flg_op_ctx #(
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic              tgt_bit_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
      tgt_o  <= 1'b0;
    end else if (start_i) begin
      bank_o <= bank_i;
      // erased cells read 1
      tgt_o  <= erase_i | tgt_bit_i;
    end
  end
endmodule

// File: rtl/flg_toggle.sv
module flg_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tog_o <= 1'b0;
    else if (clr_i) tog_o <= 1'b0;
    else if (adv_i) tog_o <= ~tog_o;
  end
endmodule

// File: rtl/flg_word_mux.sv
module flg_word_mux #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_stb_i,
  input  logic                       hit_i,
  input  logic [flg_pkg::STAT_W-1:0] status_i,
  input  logic [DATA_W-1:0]          array_i,
  output logic [DATA_W-1:0]          data_o
);
  localparam int unsigned PAD_W = DATA_W - flg_pkg::STAT_W;

  logic [DATA_W-1:0] status_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_ext = {{PAD_W{1'b0}}, status_i};
    end else begin : g_nopad
      assign status_ext = status_i[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_o <= '0;
    else if (rd_stb_i) data_o <= hit_i ? status_ext : array_i;
  end
endmodule

// File: rtl/flg_status_gen.sv
module flg_status_gen #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic              tgt_bit_i,
  input  logic [BANK_W-1:0] op_bank_i,
  input  logic              op_busy_i,
  input  logic              op_fail_i,
  input  logic              op_tmo_i,
  input  logic              rd_stb_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [BANK_W-1:0]          ctx_bank;
  logic                       ctx_tgt;
  logic                       tog;
  logic                       stat_mode;
  logic                       hit;
  logic [flg_pkg::STAT_W-1:0] status_w;

  flg_op_ctx #(.BANK_W(BANK_W)) ctx_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (op_start_i),
    .erase_i   (op_erase_i),
    .tgt_bit_i (tgt_bit_i),
    .bank_i    (op_bank_i),
    .bank_o    (ctx_bank),
    .tgt_o     (ctx_tgt)
  );

  assign stat_mode = op_busy_i | op_fail_i;
  assign hit       = rd_stb_i & stat_mode & (rd_bank_i == ctx_bank);

  flg_toggle tog_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (op_start_i),
    .adv_i  (hit),
    .tog_o  (tog)
  );

  assign status_w = flg_pkg::pack_status(ctx_tgt, tog, op_tmo_i);

  flg_word_mux #(.DATA_W(DATA_W)) mux_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_stb_i (rd_stb_i),
    .hit_i    (hit),
    .status_i (status_w),
    .array_i  (array_data_i),
    .data_o   (rd_data_o)
  );
endmodule

// File: rtl/flg_status_chk.sv
module flg_status_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_start_i,
  input logic              op_erase_i,
  input logic [BANK_W-1:0] op_bank_i,
  input logic              op_busy_i,
  input logic              op_fail_i,
  input logic              op_tmo_i,
  input logic              rd_stb_i,
  input logic [BANK_W-1:0] rd_bank_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o
);
  logic [BANK_W-1:0] seen_bank;
  logic              seen_erase;
  logic              st_read;
  logic [DATA_W-1:0] keep_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_bank  <= '0;
      seen_erase <= 1'b0;
    end else if (op_start_i) begin
      seen_bank  <= op_bank_i;
      seen_erase <= op_erase_i;
    end
  end

  assign st_read   = rd_stb_i && (op_busy_i || op_fail_i) && (rd_bank_i == seen_bank);
  assign keep_mask = DATA_W'(flg_pkg::STAT_MASK);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o));

  // R3
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !op_busy_i && !op_fail_i) |=> rd_data_o == $past(array_data_i));

  // R4
  other_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && (op_busy_i || op_fail_i) && rd_bank_i != seen_bank)
      |=> rd_data_o == $past(array_data_i));

  // R11
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_read |=> (rd_data_o & ~keep_mask) == '0);

  // R9
  tmo_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_read |=> rd_data_o[flg_pkg::TMO_POS] == $past(op_tmo_i));

  // R8
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_read && seen_erase) |=> !rd_data_o[flg_pkg::POLL_POS]);
endmodule

bind flg_status_gen flg_status_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_start_i   (op_start_i),
  .op_erase_i   (op_erase_i),
  .op_bank_i    (op_bank_i),
  .op_busy_i    (op_busy_i),
  .op_fail_i    (op_fail_i),
  .op_tmo_i     (op_tmo_i),
  .rd_stb_i     (rd_stb_i),
  .rd_bank_i    (rd_bank_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o)
);

// File: tb/flg_status_gen_tb_top.sv
`timescale 1ns/1ps
module flg_status_gen_tb_top;
  localparam int DATA_W = 16;
  localparam int BANK_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_start = 0, op_erase = 0, tgt_bit = 0;
  logic [BANK_W-1:0] op_bank = '0;
  logic              op_busy = 0, op_fail = 0, op_tmo = 0;
  logic              rd_stb = 0;
  logic [BANK_W-1:0] rd_bank = '0;
  logic [DATA_W-1:0] arr = '0;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flg_status_gen #(.DATA_W(DATA_W), .BANK_W(BANK_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .op_erase_i(op_erase),
    .tgt_bit_i(tgt_bit), .op_bank_i(op_bank), .op_busy_i(op_busy),
    .op_fail_i(op_fail), .op_tmo_i(op_tmo), .rd_stb_i(rd_stb),
    .rd_bank_i(rd_bank), .array_data_i(arr), .rd_data_o(rd_data));

  // behavioural reference
  int m_tog, m_bank, m_poll, m_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tog = 0; m_bank = 0; m_poll = 1; m_data = 0;
    end else begin
      if (rd_stb) begin
        if ((op_busy || op_fail) && int'(rd_bank) == m_bank) begin
          m_data = m_poll * 128 + m_tog * 64 + int'(op_tmo) * 32;
          m_tog  = 1 - m_tog;
        end else m_data = int'(arr);
      end
      if (op_start) begin
        m_tog  = 0;
        m_bank = int'(op_bank);
        m_poll = (op_erase || tgt_bit) ? 0 : 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (int'(rd_data) != m_data) begin
      errors++;
      $display("FAIL R2 model compare: got %h exp %h", rd_data, m_data[DATA_W-1:0]);
    end
  end

  task automatic chk(input string req, input logic [DATA_W-1:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, rd_data, exp);
    end
  endtask

  task automatic rd(input int bank, input logic [DATA_W-1:0] a);
    @(negedge clk);
    rd_stb = 1; rd_bank = BANK_W'(bank); arr = a;
    @(negedge clk);
    rd_stb = 0; arr = 16'hDEAD;
  endtask

  task automatic start(input int bank, input logic er, input logic tb);
    @(negedge clk);
    op_start = 1; op_bank = BANK_W'(bank); op_erase = er; tgt_bit = tb; op_busy = 1;
    @(negedge clk);
    op_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 16'h0000);
    rst_n = 1;
    rd(2, 16'h1234);   chk("R3 idle read", 16'h1234);
    start(3, 0, 1);
    rd(3, 16'hFFFF);   chk("R7 R5 first status", 16'h0000);
    rd(1, 16'hABCD);   chk("R4 other bank", 16'hABCD);
    rd(3, 16'hFFFF);   chk("R4 R5 toggle kept", 16'h0040);
    repeat (3) @(negedge clk);
    chk("R2 hold", 16'h0040);
    rd(3, 16'hFFFF);   chk("R11 R5 toggle back", 16'h0000);
    op_tmo = 1;
    rd(3, 16'hFFFF);   chk("R9 timeout set", 16'h0060);
    rd(3, 16'hFFFF);   chk("R9 toggle runs", 16'h0020);
    op_tmo = 0; op_busy = 0;
    rd(3, 16'h5A5A);   chk("R6 done array", 16'h5A5A);
    start(0, 0, 0);
    rd(0, 16'h0000);   chk("R7 tgt0 poll", 16'h0080);
    rd(0, 16'h0000);   chk("R7 tgt0 toggle", 16'h00C0);
    op_busy = 0; op_fail = 1;
    rd(0, 16'h0000);   chk("R10 fail poll", 16'h0080);
    rd(0, 16'h0000);   chk("R10 fail toggle", 16'h00C0);
    op_fail = 0;
    rd(0, 16'h7E81);   chk("R10 fail cleared", 16'h7E81);
    start(5, 1, 0);
    rd(5, 16'hFFFF);   chk("R8 erase poll", 16'h0000);
    rd(5, 16'hFFFF);   chk("R8 erase toggle", 16'h0040);
    rd(5, 16'hFFFF);   chk("R8 erase toggle2", 16'h0000);
    start(5, 0, 1);
    rd(5, 16'hFFFF);   chk("R6 R5 restart clears toggle", 16'h0000);
    op_busy = 0;
    rd(5, 16'h0F0F);   chk("R3 end", 16'h0F0F);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule